// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritizer

This block tracks the interrupt sources of a 16550-style serial port, picks the most urgent enabled one, and presents it as an 8-bit identification value with an active-high interrupt request. The sources are line errors, received data, receive character timeout, transmitter empty and modem status change. Each source is fed by event pulses or levels from the surrounding port logic and is cleared by the register accesses that service it.

The identification value is registered. While the host holds the identification read strobe, the value is frozen. Events that arrive during the read are recorded and appear once the read ends. Completing a read that reported the transmitter-empty source clears that source. The character timeout works only in FIFO mode. It measures four character times with a counter whose length per character comes from an input, and any push or pop of the receive FIFO restarts the count.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `iir` reads 0x01 (bits 3..0 = 0001, no interrupt pending). Whenever bit 0 is 1, bits 3..1 are 000.
- R2: If several enabled sources are pending, bits 3..0 report them in this order, most urgent first: line error (0110), received data (0100), then character timeout (1100), transmitter empty (0010), modem status (0000). Received data and character timeout share one level, and received data is reported before timeout.
- R3: A `line_err_evt` pulse sets the line-error source, which reports 0110. A `lsr_rd` pulse clears it. An event in the same cycle as the clear wins.
- R4: While `rx_avail` is high, the received-data source reports 0100. The source follows the level and needs no separate clear.
- R5: In FIFO mode with `rx_nonempty` high, the timeout source sets after 4×`char_ticks` clock cycles with no `rx_push` or `rx_pop` and reports 1100. A push or a pop restarts the count. An `rbr_rd` pulse clears the source. So does leaving FIFO mode or emptying the FIFO.
- R6: A `tx_empty_evt` pulse sets the transmitter-empty source, which reports 0010. It is cleared by `thr_write`, or by the end of an identification read whose frozen value reported 0010.
- R7: A `modem_evt` pulse sets the modem source, which reports 0000. A `msr_rd` pulse clears it.
- R8: Bits 5..4 always read 0. Bits 7..6 both equal `fifo_en`. Bit 3 reads 1 only in FIFO mode, and only together with bit 2.
- R9: While `iir_rd` is high, `iir` does not change. Events recorded during the read appear in the cycle after `iir_rd` falls.
- R10: Only sources whose `src_en` bit is set are reported. The enable bits are: bit 0 for received data and timeout, bit 1 for transmitter empty, bit 2 for line error, bit 3 for modem status. A masked source stays recorded and is reported once it is enabled.
- R11: `irq` is high exactly when `iir` bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| src_en | input | 4 | Per-source enables (see R10) |
| char_ticks | input | CT_W | Clock cycles per character time |
| line_err_evt | input | 1 | Pulse: overrun, parity, framing or break detected |
| rx_avail | input | 1 | Level: receive data available (at or above trigger, or byte held) |
| rx_nonempty | input | 1 | Level: receive FIFO holds at least one character |
| rx_push | input | 1 | Pulse: character written into receive FIFO |
| rx_pop | input | 1 | Pulse: character taken from receive FIFO |
| tx_empty_evt | input | 1 | Pulse: transmit holding register became empty |
| thr_write | input | 1 | Pulse: host write to transmit holding register |
| modem_evt | input | 1 | Pulse: modem status change detected |
| iir_rd | input | 1 | Level: host read of the identification value in progress |
| lsr_rd | input | 1 | Pulse: host read of line status |
| rbr_rd | input | 1 | Pulse: host read of receive buffer |
| msr_rd | input | 1 | Pulse: host read of modem status |
| iir | output | 8 | Identification value |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench raises a line error while an identification read is held. A design without the freeze would show 0110 during the read, and one that dropped the event would stay at 0001 afterwards. The bench also ends a read that reported transmitter-empty and checks that the source clears. Getting that clear wrong would leave 0010 stuck, or wrongly clear the source after reads that reported something else. The timeout is probed before its four-character window ends, again after a restarting push, and in non-FIFO mode. An off-by-window counter, a missing restart or a timeout leaking into non-FIFO mode each produce a wrong 1100. Stacked sources are released one at a time, which exposes any swapped priority level.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam logic [3:0] ID_NONE    = 4'b0001;
    localparam logic [3:0] ID_LINE    = 4'b0110;
    localparam logic [3:0] ID_RXDATA  = 4'b0100;
    localparam logic [3:0] ID_RXTMO   = 4'b1100;
    localparam logic [3:0] ID_TXEMPTY = 4'b0010;
    localparam logic [3:0] ID_MODEM   = 4'b0000;

    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic rxtmo;
        logic txempty;
        logic modem;
    } pend_t;

endpackage

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
    parameter int CT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fifo_en,
    input  logic            rx_nonempty,
    input  logic            rx_push,
    input  logic            rx_pop,
    input  logic            rbr_rd,
    input  logic [CT_W-1:0] char_ticks,
    output logic            tmo
);
    localparam int TW = CT_W + 2;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          tmo;
    } tmo_state_t;

    tmo_state_t st_q, st_d;
    logic [TW-1:0] window_last_d;
    logic          armed_d;

    always_comb begin
        st_d = st_q;
        if (char_ticks == '0) begin
            window_last_d = TW'(3);
        end else begin
            window_last_d = {char_ticks, 2'b00} - TW'(1);
        end
        armed_d = fifo_en && rx_nonempty && !rx_push && !rx_pop && !st_q.tmo;
        if (armed_d) begin
            if (st_q.cnt == window_last_d) begin
                st_d.cnt = '0;
                st_d.tmo = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + TW'(1);
            end
        end else begin
            st_d.cnt = '0;
        end
        if (!fifo_en || !rx_nonempty || rbr_rd) begin
            st_d.tmo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tmo = st_q.tmo;
endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_err_evt,
    input  logic       lsr_rd,
    input  logic       tx_empty_evt,
    input  logic       thr_write,
    input  logic       modem_evt,
    input  logic       msr_rd,
    input  logic       read_done,
    input  logic [3:0] shown_id,
    output logic       line_pend,
    output logic       tx_pend,
    output logic       modem_pend
);
    typedef struct packed {
        logic line;
        logic txempty;
        logic modem;
    } src_state_t;

    src_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (lsr_rd)       st_d.line = 1'b0;
        if (line_err_evt) st_d.line = 1'b1;
        if (thr_write || (read_done && shown_id == ID_TXEMPTY)) st_d.txempty = 1'b0;
        if (tx_empty_evt) st_d.txempty = 1'b1;
        if (msr_rd)       st_d.modem = 1'b0;
        if (modem_evt)    st_d.modem = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_pend  = st_q.line;
    assign tx_pend    = st_q.txempty;
    assign modem_pend = st_q.modem;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  pend_t      pend,
    input  logic [3:0] src_en,
    input  logic       fifo_en,
    output logic [3:0] id
);
    always_comb begin
        if (pend.line && src_en[EN_LINE]) begin
            id = ID_LINE;
        end else if (pend.rxdata && src_en[EN_RX]) begin
            id = ID_RXDATA;
        end else if (pend.rxtmo && fifo_en && src_en[EN_RX]) begin
            id = ID_RXTMO;
        end else if (pend.txempty && src_en[EN_TX]) begin
            id = ID_TXEMPTY;
        end else if (pend.modem && src_en[EN_MODEM]) begin
            id = ID_MODEM;
        end else begin
            id = ID_NONE;
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fifo_en,
    input  logic [3:0]      src_en,
    input  logic [CT_W-1:0] char_ticks,
    input  logic            line_err_evt,
    input  logic            rx_avail,
    input  logic            rx_nonempty,
    input  logic            rx_push,
    input  logic            rx_pop,
    input  logic            tx_empty_evt,
    input  logic            thr_write,
    input  logic            modem_evt,
    input  logic            iir_rd,
    input  logic            lsr_rd,
    input  logic            rbr_rd,
    input  logic            msr_rd,
    output logic [7:0]      iir,
    output logic            irq
);
    typedef struct packed {
        logic [7:0] iir;
        logic       rd;
    } view_state_t;

    view_state_t vw_q, vw_d;
    pend_t       pend;
    logic [3:0]  id_now;
    logic        read_done;
    logic        line_pend, tx_pend, modem_pend, tmo_pend;

    assign read_done = vw_q.rd && !iir_rd;

    uart_irq_sources u_src (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_err_evt (line_err_evt),
        .lsr_rd       (lsr_rd),
        .tx_empty_evt (tx_empty_evt),
        .thr_write    (thr_write),
        .modem_evt    (modem_evt),
        .msr_rd       (msr_rd),
        .read_done    (read_done),
        .shown_id     (vw_q.iir[3:0]),
        .line_pend    (line_pend),
        .tx_pend      (tx_pend),
        .modem_pend   (modem_pend)
    );

    uart_irq_timeout #(.CT_W(CT_W)) u_tmo (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_en     (fifo_en),
        .rx_nonempty (rx_nonempty),
        .rx_push     (rx_push),
        .rx_pop      (rx_pop),
        .rbr_rd      (rbr_rd),
        .char_ticks  (char_ticks),
        .tmo         (tmo_pend)
    );

    always_comb begin
        pend.line    = line_pend;
        pend.rxdata  = rx_avail;
        pend.rxtmo   = tmo_pend;
        pend.txempty = tx_pend;
        pend.modem   = modem_pend;
    end

    uart_irq_prio u_prio (
        .pend    (pend),
        .src_en  (src_en),
        .fifo_en (fifo_en),
        .id      (id_now)
    );

    always_comb begin
        vw_d    = vw_q;
        vw_d.rd = iir_rd;
        if (!iir_rd) begin
            vw_d.iir = {fifo_en, fifo_en, 2'b00, id_now};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vw_q.iir <= {4'b0000, ID_NONE};
            vw_q.rd  <= 1'b0;
        end else begin
            vw_q <= vw_d;
        end
    end

    assign iir = vw_q.iir;
    assign irq = !vw_q.iir[0];
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
    import uart_irq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] src_en,
    input logic       iir_rd,
    input logic       tx_empty_evt,
    input logic [7:0] iir,
    input logic       line_pend,
    input logic       tx_pend
);
    // R8
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iir[5:4] == 2'b00);

    // R8
    tmo_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iir[3] |-> (iir[2] && iir[7] && iir[6]));

    // R1
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iir[0] |-> (iir[3:1] == 3'b000));

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rd |=> $stable(iir));

    // R2
    line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pend && src_en[EN_LINE] && !iir_rd) |=> (iir[3:0] == ID_LINE));

    // R6
    tx_readclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(iir_rd) && !iir_rd && iir[3:0] == ID_TXEMPTY && !tx_empty_evt) |=> !tx_pend);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_en       (src_en),
    .iir_rd       (iir_rd),
    .tx_empty_evt (tx_empty_evt),
    .iir          (iir),
    .line_pend    (line_pend),
    .tx_pend      (tx_pend)
);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
    localparam int CT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b0;
    logic [3:0] src_en = 4'hF;
    logic [CT_W-1:0] char_ticks = 16'd4;
    logic line_err_evt = 0, rx_avail = 0, rx_nonempty = 0, rx_push = 0, rx_pop = 0;
    logic tx_empty_evt = 0, thr_write = 0, modem_evt = 0;
    logic iir_rd = 0, lsr_rd = 0, rbr_rd = 0, msr_rd = 0;
    logic [7:0] iir;
    logic irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    uart_irq_ident #(.CT_W(CT_W)) dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .src_en(src_en),
        .char_ticks(char_ticks), .line_err_evt(line_err_evt), .rx_avail(rx_avail),
        .rx_nonempty(rx_nonempty), .rx_push(rx_push), .rx_pop(rx_pop),
        .tx_empty_evt(tx_empty_evt), .thr_write(thr_write), .modem_evt(modem_evt),
        .iir_rd(iir_rd), .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .msr_rd(msr_rd),
        .iir(iir), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        tick(1);
        chk8("R1 reset iir", iir, 8'h01);
        chk8("R11 reset irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_line;
        line_err_evt = 1; tick(1); line_err_evt = 0; tick(1);
        chk8("R3 line error id", iir, 8'h06);
        chk8("R11 irq on pending", {7'd0, irq}, 8'h01);
        lsr_rd = 1; tick(1); lsr_rd = 0; tick(1);
        chk8("R3 line cleared by lsr read", iir, 8'h01);
    endtask

    task automatic t_prio;
        tx_empty_evt = 1; modem_evt = 1; line_err_evt = 1; rx_avail = 1;
        tick(1);
        tx_empty_evt = 0; modem_evt = 0; line_err_evt = 0;
        tick(1);
        chk8("R2 line over all", iir, 8'h06);
        lsr_rd = 1; tick(1); lsr_rd = 0; tick(1);
        chk8("R2 rxdata next", iir, 8'h04);
        rx_avail = 0; tick(2);
        chk8("R2 txempty next", iir, 8'h02);
        thr_write = 1; tick(1); thr_write = 0; tick(1);
        chk8("R2 R6 modem last after thr write", iir, 8'h00);
        chk8("R11 irq for modem", {7'd0, irq}, 8'h01);
        msr_rd = 1; tick(1); msr_rd = 0; tick(1);
        chk8("R7 modem cleared by msr read", iir, 8'h01);
    endtask

    task automatic t_rda;
        rx_avail = 1; tick(2);
        chk8("R4 rxdata level", iir, 8'h04);
        rx_avail = 0; tick(2);
        chk8("R4 rxdata drops with level", iir, 8'h01);
    endtask

    task automatic t_tx_read;
        tx_empty_evt = 1; tick(1); tx_empty_evt = 0; tick(1);
        chk8("R6 txempty id", iir, 8'h02);
        iir_rd = 1; tick(2);
        chk8("R6 txempty during read", iir, 8'h02);
        iir_rd = 0; tick(2);
        chk8("R6 txempty cleared by id read", iir, 8'h01);
    endtask

    task automatic t_mask;
        src_en = 4'b0000;
        line_err_evt = 1; tick(1); line_err_evt = 0; tick(1);
        chk8("R10 masked line not shown", iir, 8'h01);
        chk8("R10 masked irq low", {7'd0, irq}, 8'h00);
        src_en = 4'hF; tick(2);
        chk8("R10 line kept then shown", iir, 8'h06);
        lsr_rd = 1; tick(1); lsr_rd = 0; tick(1);
    endtask

    task automatic t_freeze;
        iir_rd = 1; tick(1);
        line_err_evt = 1; tick(1); line_err_evt = 0;
        tick(3);
        chk8("R9 frozen during read", iir, 8'h01);
        iir_rd = 0; tick(1);
        chk8("R9 event shown after read", iir, 8'h06);
        lsr_rd = 1; tick(1); lsr_rd = 0; tick(1);
    endtask

    task automatic t_fifo_bits;
        fifo_en = 1; tick(2);
        chk8("R8 fifo bits set", iir, 8'hC1);
    endtask

    task automatic t_timeout;
        rx_nonempty = 1;
        rx_push = 1; tick(1); rx_push = 0;
        tick(8);
        chk8("R5 no timeout before window", iir, 8'hC1);
        rx_push = 1; tick(1); rx_push = 0;
        tick(10);
        chk8("R5 push restarts window", iir, 8'hC1);
        tick(10);
        chk8("R5 timeout id", iir, 8'hCC);
        rbr_rd = 1; rx_pop = 1; rx_nonempty = 0; tick(1);
        rbr_rd = 0; rx_pop = 0; tick(2);
        chk8("R5 timeout cleared by rbr read", iir, 8'hC1);
    endtask

    task automatic t_nofifo;
        fifo_en = 0; rx_nonempty = 1;
        tick(40);
        chk8("R8 R5 no timeout outside fifo mode", iir, 8'h01);
        rx_nonempty = 0; tick(1);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1;
        t_reset();
        t_line();
        t_prio();
        t_rda();
        t_tx_read();
        t_mask();
        t_freeze();
        t_fifo_bits();
        t_timeout();
        t_nofifo();
        finish_run();
    end
endmodule